// File: doc/BRIEF.md
# Integer Multiply and Negate Execution Unit

This unit is one execution lane of a 32-bit RISC integer pipeline. It covers five operations: two's-complement negation, the low word of a signed 32x32 product, the low word of a product with a sign-extended 16-bit immediate, and the high word of a 32x32 product taken either signed or unsigned. Two qualifier bits come with each operation. The record bit asks for an update of a 4-bit condition field. The overflow-enable bit asks for an update of the overflow (OV) and sticky summary-overflow (SO) bits. The two bits act independently. Any variant that the operation does not define is ignored.

Operations enter through a valid/ready input stream and leave through a valid/ready output stream, with one register stage between them. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). So a stalled consumer stops new operations from entering, and back-to-back operations flow at one per cycle. The condition field and the OV/SO bits are architectural state. They are written on the accepting edge, so they become visible together with the result that caused them.

Top module: `mulneg_unit`

## Requirements
- R1: Opcode encoding on `in_op`: 0 negate, 1 multiply-low-word, 2 multiply-low-immediate, 3 signed multiply-high-word, 4 unsigned multiply-high-word. Negate returns the bitwise inverse of `in_a` plus one.
- R2: Multiply-low-word returns bits [31:0] of the 64-bit product of `in_a` and `in_b`.
- R3: Multiply-low-immediate returns bits [31:0] of `in_a` times `in_imm`, where `in_imm` is sign-extended from bit 15 to 32 bits.
- R4: Signed multiply-high-word returns bits [63:32] of the product with both operands taken as signed.
- R5: Unsigned multiply-high-word returns bits [63:32] of the product with both operands taken as unsigned.
- R6: When an accepted operation has neither the record bit nor the overflow-enable bit, `cr_field`, `xer_ov` and `xer_so` keep their values.
- R7: A recorded operation writes `cr_field` as follows: bit 3 = result negative (bit 31 set), bit 2 = result positive (bit 31 clear and nonzero), bit 1 = result zero, bit 0 = SO after any update made by the same operation. Recording is defined for negate, multiply-low-word and both multiply-high forms. Multiply-low-immediate ignores `in_rec`.
- R8: Multiply-low-word with overflow enabled sets OV when the signed 64-bit product falls outside the signed 32-bit range and clears OV otherwise. SO becomes SO OR the new OV, and this unit never clears SO.
- R9: Negate with overflow enabled sets OV exactly when `in_a` is 0x80000000. In that case the result is 0x80000000. SO is updated as in R8.
- R10: `in_oe` is ignored for multiply-low-immediate and both multiply-high forms: OV and SO keep their values.
- R11: `in_ready` equals `!out_valid || out_ready`. The result and its flag updates appear with `out_valid` on the edge after acceptance. While `out_valid` is high and `out_ready` is low, `out_res` and `out_valid` hold.
- R12: A synchronous reset (`rst` high) clears `out_valid`, `xer_so`, `xer_ov` and `cr_field`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Operation code (R1) |
| in_rec | input | 1 | Record variant: update the condition field |
| in_oe | input | 1 | Overflow-enabled variant: update OV and SO |
| in_a | input | 32 | First register operand |
| in_b | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate for multiply-low-immediate |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 32 | Result |
| cr_field | output | 4 | Condition field {neg, pos, zero, so} |
| xer_so | output | 1 | Sticky summary overflow |
| xer_ov | output | 1 | Overflow of the last overflow-enabled operation |

## Verification
Within a single accepted operation, the overflow update and the condition-field update coincide when both the record bit and the overflow-enable bit are set. The condition field's SO copy must then reflect the SO value after that same operation's OV result, not the value before it. The bench provokes this with overflowing multiply-low-word and negate-of-minimum operations that carry both qualifier bits, starting from a state where SO is clear. A scoreboard model applies the OV/SO update first and derives the condition field from it, then compares every field when the result leaves the unit, including under random output stalls.

// File: rtl/mn_pkg.sv
package mn_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned IMMW = 16;
  localparam int unsigned OPW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_NEG    = 3'd0,
    OP_MULLW  = 3'd1,
    OP_MULLI  = 3'd2,
    OP_MULHW  = 3'd3,
    OP_MULHWU = 3'd4
  } mn_op_e;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } mn_cond_t;
endpackage

// File: rtl/mn_decode.sv
module mn_decode
  import mn_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           rec,
  input  logic           oe,
  output logic           rec_eff,
  output logic           oe_eff
);
  logic rec_ok;
  logic oe_ok;

  always_comb begin
    rec_ok = 1'b0;
    oe_ok  = 1'b0;
    case (mn_op_e'(op))
      OP_NEG:    begin rec_ok = 1'b1; oe_ok = 1'b1; end
      OP_MULLW:  begin rec_ok = 1'b1; oe_ok = 1'b1; end
      OP_MULHW:  rec_ok = 1'b1;
      OP_MULHWU: rec_ok = 1'b1;
      default:   begin rec_ok = 1'b0; oe_ok = 1'b0; end
    endcase
  end

  assign rec_eff = rec & rec_ok;
  assign oe_eff  = oe & oe_ok;
endmodule

// File: rtl/mn_datapath.sv
module mn_datapath
  import mn_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned IW = IMMW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   res,
  output logic           ovf
);
  localparam int unsigned MW = W + 1;      // multiplier operand width
  localparam int unsigned PW = 2 * MW;     // full product width

  logic          a_signed;
  logic [W-1:0]  b_sel;
  logic [MW-1:0] ma;
  logic [MW-1:0] mb;
  logic [PW-1:0] prod;
  logic [W-1:0]  neg_res;
  logic          neg_ovf;
  logic          lo_ovf;

  // one shared signed (W+1)x(W+1) multiplier; the extra bit carries either
  // the sign or a zero, depending on whether the operands are unsigned
  assign a_signed = (mn_op_e'(op) != OP_MULHWU);
  assign b_sel    = (mn_op_e'(op) == OP_MULLI) ? {{(W-IW){imm[IW-1]}}, imm} : b;
  assign ma       = {a_signed & a[W-1], a};
  assign mb       = {a_signed & b_sel[W-1], b_sel};
  assign prod     = {{MW{ma[MW-1]}}, ma} * {{MW{mb[MW-1]}}, mb};

  // low word fits in W signed bits only if the high word is its sign copy
  assign lo_ovf   = (prod[2*W-1:W] != {W{prod[W-1]}});

  assign neg_res  = ~a + W'(1);
  assign neg_ovf  = (a == {1'b1, {(W-1){1'b0}}});

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (mn_op_e'(op))
      OP_NEG:    begin res = neg_res; ovf = neg_ovf; end
      OP_MULLW:  begin res = prod[W-1:0]; ovf = lo_ovf; end
      OP_MULLI:  res = prod[W-1:0];
      OP_MULHW:  res = prod[2*W-1:W];
      OP_MULHWU: res = prod[2*W-1:W];
      default:   begin res = '0; ovf = 1'b0; end
    endcase
  end

  // R9: negating the most negative value gives it back
  always_comb begin
    if (mn_op_e'(op) == OP_NEG && neg_ovf)
      assert (res == a) else $error("p_neg_min_r9 violated");
  end
endmodule

// File: rtl/mn_flags.sv
module mn_flags
  import mn_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         upd_cr,
  input  logic         upd_ov,
  input  logic         ovf,
  input  logic [W-1:0] res,
  output mn_cond_t     cond,
  output logic         so,
  output logic         ov
);
  mn_cond_t cond_q;
  logic     so_q;
  logic     ov_q;
  logic     so_nx;
  logic     cr_fire;
  logic     ov_fire;

  assign cr_fire = fire & upd_cr;
  assign ov_fire = fire & upd_ov;
  assign so_nx   = so_q | (upd_ov & ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      so_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      if (ov_fire) begin
        ov_q <= ovf;
        so_q <= so_nx;
      end
      if (cr_fire) begin
        cond_q.neg  <= res[W-1];
        cond_q.pos  <= ~res[W-1] & (|res);
        cond_q.zero <= ~(|res);
        cond_q.so   <= so_nx;
      end
    end
  end

  assign cond = cond_q;
  assign so   = so_q;
  assign ov   = ov_q;

  p_so_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    so_q |=> so_q);

  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ov_fire |=> $stable(ov_q) && $stable(so_q));

  p_cond_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cr_fire |=> $stable(cond_q));

  p_cond_class_r7: assert property (@(posedge clk) disable iff (rst)
    cr_fire |=> ($countones({cond_q.neg, cond_q.pos, cond_q.zero}) == 1)
                && (cond_q.so == so_q));
endmodule

// File: rtl/mulneg_unit.sv
module mulneg_unit
  import mn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_op,
  input  logic        in_rec,
  input  logic        in_oe,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [15:0] in_imm,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_res,
  output logic [3:0]  cr_field,
  output logic        xer_so,
  output logic        xer_ov
);
  logic            fire;
  logic            rec_eff;
  logic            oe_eff;
  logic [XLEN-1:0] dp_res;
  logic            dp_ovf;
  logic            vld_q;
  logic [XLEN-1:0] res_q;
  mn_cond_t        cond;

  assign in_ready = ~vld_q | out_ready;
  assign fire     = in_valid & in_ready;

  mn_decode u_dec (
    .op      (in_op),
    .rec     (in_rec),
    .oe      (in_oe),
    .rec_eff (rec_eff),
    .oe_eff  (oe_eff)
  );

  mn_datapath #(.W(XLEN), .IW(IMMW)) u_dp (
    .op  (in_op),
    .a   (in_a),
    .b   (in_b),
    .imm (in_imm),
    .res (dp_res),
    .ovf (dp_ovf)
  );

  mn_flags #(.W(XLEN)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .upd_cr (rec_eff),
    .upd_ov (oe_eff),
    .ovf    (dp_ovf),
    .res    (dp_res),
    .cond   (cond),
    .so     (xer_so),
    .ov     (xer_ov)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (fire) begin
      vld_q <= 1'b1;
      res_q <= dp_res;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_res   = res_q;
  assign cr_field  = cond;

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_res));

  p_launch_r11: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_negmin_out_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 3'd0 && in_a == 32'h8000_0000) |=> out_res == 32'h8000_0000);
endmodule

// File: tb/mulneg_unit_tb_top.sv
module mulneg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_rec = 1'b0;
  logic        in_oe = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic [3:0]  cr_field;
  logic        xer_so;
  logic        xer_ov;

  always #5 clk = ~clk;

  mulneg_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rec(in_rec), .in_oe(in_oe), .in_a(in_a), .in_b(in_b),
    .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .cr_field(cr_field), .xer_so(xer_so), .xer_ov(xer_ov)
  );

  typedef struct {
    logic [31:0] res;
    logic [3:0]  cr;
    logic        so;
    logic        ov;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  logic m_so = 1'b0;
  logic m_ov = 1'b0;
  logic [3:0] m_cr = '0;
  logic force_stall = 1'b0;
  logic rand_stall = 1'b0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model, written from the requirements
  task automatic model(input logic [2:0] op, input logic rec, input logic oe,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, output logic [31:0] r);
    longint pa, pb, pi, ps;
    logic [63:0] t;
    logic ovm, use_oe, use_rec;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pi = longint'($signed(imm));
    ovm = 1'b0;
    r = '0;
    case (op)
      3'd0: begin r = 32'd0 - a; ovm = (a == 32'h8000_0000); end
      3'd1: begin ps = pa * pb; t = ps; r = t[31:0];
                  ovm = (ps > 64'sd2147483647) || (ps < -64'sd2147483648); end
      3'd2: begin ps = pa * pi; t = ps; r = t[31:0]; end
      3'd3: begin ps = pa * pb; t = ps; r = t[63:32]; end
      3'd4: begin t = {32'd0, a} * {32'd0, b}; r = t[63:32]; end
      default: r = '0;
    endcase
    use_oe  = oe  && (op == 3'd0 || op == 3'd1);
    use_rec = rec && (op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4);
    if (use_oe) begin
      m_ov = ovm;
      m_so = m_so | ovm;
    end
    if (use_rec)
      m_cr = {r[31], !r[31] && (r != 0), r == 0, m_so};
  endtask

  task automatic send(input logic [2:0] op, input logic rec, input logic oe,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] imm, input string tag);
    exp_t e;
    logic [31:0] r;
    @(negedge clk);
    in_op = op; in_rec = rec; in_oe = oe; in_a = a; in_b = b; in_imm = imm;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    model(op, rec, oe, a, b, imm, r);
    e.res = r; e.cr = m_cr; e.so = m_so; e.ov = m_ov; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // consumer ready generation, changed away from both edges
  always @(posedge clk) begin
    #2;
    if (force_stall) out_ready = 1'b0;
    else if (rand_stall) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected output", out_res, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_res == e.res, e.tag, "result", out_res, e.res);
        chk(cr_field == e.cr && xer_so == e.so && xer_ov == e.ov, e.tag,
            "cr/so/ov", {26'd0, cr_field, xer_so, xer_ov},
            {26'd0, e.cr, e.so, e.ov});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R12", "valid/ready after reset",
        {30'd0, out_valid, in_ready}, 32'h1);
    chk(cr_field == 4'd0 && !xer_so && !xer_ov, "R12", "flags after reset",
        {26'd0, cr_field, xer_so, xer_ov}, 32'h0);

    // R1 negate
    send(3'd0, 0, 0, 32'd5, 32'd0, 16'd0, "R1");
    send(3'd0, 0, 0, 32'd0, 32'd0, 16'd0, "R1");
    send(3'd0, 0, 0, 32'hFFFF_FFFF, 32'd0, 16'd0, "R1");
    // R2 multiply-low-word
    send(3'd1, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 16'd0, "R2");
    send(3'd1, 0, 0, 32'hFFFF_FFFD, 32'd7, 16'd0, "R2");
    // R3 multiply-low-immediate, immediate sign-extended
    send(3'd2, 0, 0, 32'd1000, 32'd0, 16'hFFFF, "R3");
    send(3'd2, 0, 0, 32'h0001_0003, 32'hDEAD_BEEF, 16'h7FFF, "R3");
    send(3'd2, 0, 0, 32'hFFFF_FFFE, 32'd0, 16'h8000, "R3");
    // R4 signed high
    send(3'd3, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R4");
    send(3'd3, 0, 0, 32'h8000_0000, 32'h8000_0000, 16'd0, "R4");
    send(3'd3, 0, 0, 32'hFFFF_FFFE, 32'd3, 16'd0, "R4");
    // R5 unsigned high
    send(3'd4, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R5");
    send(3'd4, 0, 0, 32'h8000_0000, 32'd2, 16'd0, "R5");
    // R7 record forms
    send(3'd0, 1, 0, 32'd5, 32'd0, 16'd0, "R7");
    send(3'd3, 1, 0, 32'd3, 32'd4, 16'd0, "R7");
    send(3'd1, 1, 0, 32'd6, 32'd7, 16'd0, "R7");
    send(3'd4, 1, 0, 32'hFFFF_FFFF, 32'h2, 16'd0, "R7");
    send(3'd2, 1, 0, 32'hFFFF_FFFF, 32'd0, 16'd1, "R7"); // rec ignored
    // R8 overflow on multiply-low-word, with SO copy in the same cycle
    send(3'd1, 1, 1, 32'h0001_0000, 32'h0001_0000, 16'd0, "R8");
    send(3'd1, 0, 1, 32'd2, 32'd3, 16'd0, "R8");
    send(3'd1, 1, 1, 32'h7FFF_FFFF, 32'd1, 16'd0, "R8");
    send(3'd1, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0, "R8");
    // R6 plain forms leave flags alone
    send(3'd1, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'd0, "R6");
    send(3'd0, 0, 0, 32'h8000_0000, 32'd0, 16'd0, "R6");
    drain();

    // R12 reset mid-run after SO was set, then R9 from a clear state
    @(negedge clk); rst = 1'b1;
    m_so = 0; m_ov = 0; m_cr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cr_field == 4'd0 && !xer_so && !xer_ov && !out_valid, "R12",
        "flags after mid-run reset", {25'd0, out_valid, cr_field, xer_so, xer_ov}, 32'h0);
    send(3'd0, 1, 1, 32'h8000_0000, 32'd0, 16'd0, "R9");
    send(3'd0, 0, 1, 32'd1, 32'd0, 16'd0, "R9");
    send(3'd0, 1, 1, 32'h7FFF_FFFF, 32'd0, 16'd0, "R9");
    // R10 oe ignored by high and immediate forms
    send(3'd1, 0, 1, 32'h4000_0000, 32'd4, 16'd0, "R10");
    send(3'd4, 0, 1, 32'd1, 32'd1, 16'd0, "R10");
    send(3'd3, 0, 1, 32'd1, 32'd1, 16'd0, "R10");
    send(3'd1, 0, 1, 32'd1, 32'd1, 16'd0, "R10");
    send(3'd2, 0, 1, 32'h7FFF_FFFF, 32'd0, 16'h7FFF, "R10");
    send(3'd3, 0, 1, 32'h8000_0000, 32'h8000_0000, 16'd0, "R10");
    drain();

    // R11 back-pressure: result must hold, input must block
    force_stall = 1'b1;
    repeat (2) @(negedge clk);
    send(3'd1, 0, 0, 32'd11, 32'd13, 16'd0, "R11");
    @(negedge clk);
    held = out_res;
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R11", "stall valid/ready",
        {30'd0, out_valid, in_ready}, 32'h2);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_res == held && out_res == 32'd143, "R11",
        "held result", out_res, 32'd143);
    chk(in_ready == 1'b0, "R11", "in_ready during stall", {31'd0, in_ready}, 32'h0);
    force_stall = 1'b0;
    drain();

    // R11 random stream under random stalls
    rand_stall = 1'b1;
    for (int i = 0; i < 60; i++) begin
      send(3'($urandom % 5), 1'($urandom), 1'($urandom), $urandom, $urandom,
           16'($urandom), "R11");
    end
    rand_stall = 1'b0;
    drain();
    chk(q.size() == 0, "R11", "scoreboard empty", q.size(), 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule